// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a 16-bit timer that counts up from zero. Compare register A sets its period, and compare register B marks a point inside that period. Each counting tick comes from a single-cycle enable input, `tick_i`, which is normally a prescaled strobe. When the count reaches the period the timer wraps back to zero. On that cycle it pulses both its wrap output and its compare-A output. When the count steps onto the value held in compare register B it pulses the compare-B output.

Software reaches the timer through a simple byte-offset register port. The port gives access to a two-byte mode register, two compare/capture mode bytes, the two compare registers and a read-only view of the counter. Every access is checked for size, reserved bits and illegal combinations. An access that breaks a rule is dropped entirely: no register changes and no read data is returned. One cycle later the error output pulses.

Top module: `upcmp_timer`

## Requirements
- R1: After reset the counter reads 0, both mode bytes and both compare registers read 0, and the wrap, compare-A, compare-B and error outputs are low.
- R2: While running, each cycle with `tick_i` high adds one to the count. A counter read returns the ticks since the last start or wrap. Cycles without a tick leave the count unchanged.
- R3: With a period P, the P-th tick after a start or wrap returns the count to 0. The register stage places the wrap pulse and the compare-A pulse together in the cycle after that tick, and each lasts one cycle.
- R4: When a tick moves the count onto the value of compare register B, the compare-B output pulses for one cycle, in the cycle after that tick. A value of 0 matches on the wrap tick.
- R5: Writing mode byte 1 with bit 7 (count enable) set restarts the count at 0 and latches the current compare-A value as the period. A later write to compare A does not change the period until the next start.
- R6: If compare A is 0 when count enable is written, the timer does not run: the counter reads 0 and no pulses appear. The mode byte still stores the value written.
- R7: Writing mode byte 1 with bit 7 clear stops the timer. A stopped timer reads 0 and ignores ticks.
- R8: Mode byte 0 sits at offset 0x84. A write that sets any of its bits 5, 3 or 2 is an error.
- R9: Mode byte 1 sits at offset 0x85. A write with bits 7 and 6 both set is an error. A write with any of bits 2:0 set is an error.
- R10: Access size is encoded on `bus_size` as 0 for one byte, 1 for two bytes and 2 for four bytes; 3 is reserved. A two-byte access at 0x84 covers both mode bytes, with byte 0 on data bits 15:8 and byte 1 on bits 7:0. A two-byte access at 0x85, or any four-byte or reserved-size access, is an error.
- R11: Compare A (0xC4) and compare B (0xD4) accept one- or two-byte access. A one-byte write replaces only bits 7:0 and keeps the upper bits. The compare/capture mode bytes (0xB4, 0xB5) accept only one-byte access.
- R12: The counter (0xA4) accepts one- or two-byte reads, and any write to it is an error. An access to an unmapped offset is an error. An error pulses `err_o` for one cycle, one cycle after the access, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable strobe, one tick per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read strobe |
| err_o | output | 1 | Access error pulse, one cycle after the faulty access |
| wrap_o | output | 1 | Wrap pulse at the end of each period |
| cmpa_o | output | 1 | Compare-A match pulse |
| cmpb_o | output | 1 | Compare-B match pulse |

## Verification
The bench writes compare A while the timer runs and checks that the period in force does not change. A design that read compare A live would wrap early. It starts the timer with compare A at zero: a design without the zero guard would pulse on every tick, or would run with a period of 65536. Every illegal mode value, access size and counter write is followed by a read-back and a count check. A design that stored the bad value, or started counting from a rejected write, shows the wrong mode byte or a moving counter. One-byte compare writes are read back whole, which exposes any design that clears or shifts the upper byte.

// File: rtl/utmr_pkg.sv
package utmr_pkg;

   localparam int BUS_W = 16;

   // register byte offsets
   localparam logic [7:0] OFF_MD0  = 8'h84;
   localparam logic [7:0] OFF_MD1  = 8'h85;
   localparam logic [7:0] OFF_CNT  = 8'hA4;
   localparam logic [7:0] OFF_CCMA = 8'hB4;
   localparam logic [7:0] OFF_CCMB = 8'hB5;
   localparam logic [7:0] OFF_CMPA = 8'hC4;
   localparam logic [7:0] OFF_CMPB = 8'hD4;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   // mode field layout
   localparam logic [7:0] MD0_RSVD = 8'h2C;
   localparam logic [7:0] MD1_RSVD = 8'h07;
   localparam int         MD1_RUN  = 7;
   localparam int         MD1_LOAD = 6;

endpackage

// File: rtl/utmr_core.sv
module utmr_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [CNT_W-1:0] cmp_a_i,
   output logic [CNT_W-1:0] cnt_view_o,
   output logic             adv_o,
   output logic [CNT_W-1:0] nxt_o,
   output logic             wrap_o,
   output logic             cmpa_o
);

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             hit_end;

   assign cnt_inc    = cnt_q + 1'b1;
   assign hit_end    = (cnt_inc == period_q);
   assign adv_o      = run_q && tick_i && !start_i && !stop_i;
   assign nxt_o      = hit_end ? '0 : cnt_inc;
   assign cnt_view_o = run_q ? cnt_q : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         cnt_q    <= '0;
         period_q <= '0;
         wrap_o   <= 1'b0;
         cmpa_o   <= 1'b0;
      end else begin
         wrap_o <= adv_o && hit_end;
         cmpa_o <= adv_o && hit_end;
         if (start_i) begin
            cnt_q <= '0;
            if (cmp_a_i != '0) begin
               run_q    <= 1'b1;
               period_q <= cmp_a_i;
            end else begin
               run_q <= 1'b0;
            end
         end else if (stop_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
         end else if (adv_o) begin
            cnt_q <= nxt_o;
         end
      end
   end

   AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q < period_q)); // R3
   AST_RUN_NONZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (period_q != '0)); // R6
   AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !start_i && !stop_i) |=> ($stable(cnt_q) && $stable(run_q))); // R2

endmodule

// File: rtl/utmr_match.sv
module utmr_match #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic [CNT_W-1:0] nxt_i,
   input  logic [CNT_W-1:0] cmp_b_i,
   output logic             cmpb_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) cmpb_o <= 1'b0;
      else        cmpb_o <= adv_i && (nxt_i == cmp_b_i);
   end

endmodule

// File: rtl/utmr_regs.sv
module utmr_regs
   import utmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic [CNT_W-1:0]  cnt_view,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              err_o,
   output logic              start_o,
   output logic              stop_o,
   output logic [CNT_W-1:0]  cmp_a,
   output logic [CNT_W-1:0]  cmp_b
);

   localparam int NCMP = 2;
   localparam int NCCM = 2;

   logic [7:0] md0_q, md1_q;
   logic       sz1, sz2;
   logic       hit_md0, hit_md1, hit_cnt;
   logic [NCCM-1:0] hit_ccm;
   logic [NCMP-1:0] hit_cmp;
   logic [NCCM-1:0][7:0]       ccm_val;
   logic [NCMP-1:0][CNT_W-1:0] cmp_val;
   logic       mapped, size_ok, val_bad, err_now, commit;
   logic       wr_b0, wr_b1;
   logic [7:0] b0, b1;
   logic [BUS_W-1:0] rd_val;

   assign sz1     = (bus_size == SZ_BYTE);
   assign sz2     = (bus_size == SZ_HALF);
   assign hit_md0 = (bus_addr == ADDR_W'(OFF_MD0));
   assign hit_md1 = (bus_addr == ADDR_W'(OFF_MD1));
   assign hit_cnt = (bus_addr == ADDR_W'(OFF_CNT));

   // compare/capture mode bytes
   for (genvar i = 0; i < NCCM; i++) begin : g_ccm
      localparam logic [7:0] OFS = (i == 0) ? OFF_CCMA : OFF_CCMB;
      logic [7:0] val_q;
      assign hit_ccm[i] = (bus_addr == ADDR_W'(OFS));
      assign ccm_val[i] = val_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                     val_q <= '0;
         else if (commit && hit_ccm[i])  val_q <= bus_wdata[7:0];
      end
   end

   // compare registers
   for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      localparam logic [7:0] OFS = (i == 0) ? OFF_CMPA : OFF_CMPB;
      logic [CNT_W-1:0] val_q;
      assign hit_cmp[i] = (bus_addr == ADDR_W'(OFS));
      assign cmp_val[i] = val_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_q <= '0;
         end else if (commit && hit_cmp[i]) begin
            if (sz2) val_q      <= bus_wdata[CNT_W-1:0];
            else     val_q[7:0] <= bus_wdata[7:0];
         end
      end
   end

   assign cmp_a = cmp_val[0];
   assign cmp_b = cmp_val[1];

   assign mapped = hit_md0 | hit_md1 | hit_cnt | (|hit_ccm) | (|hit_cmp);

   always_comb begin
      size_ok = 1'b0;
      if (hit_md0)                        size_ok = sz1 | sz2;
      else if (hit_md1 || (|hit_ccm))     size_ok = sz1;
      else if (hit_cnt || (|hit_cmp))     size_ok = sz1 | sz2;
   end

   assign b0    = sz2 ? bus_wdata[15:8] : bus_wdata[7:0];
   assign b1    = bus_wdata[7:0];
   assign wr_b0 = bus_wr && hit_md0;
   assign wr_b1 = bus_wr && ((hit_md1 && sz1) || (hit_md0 && sz2));

   assign val_bad = (wr_b0 && ((b0 & MD0_RSVD) != 8'h00))
                 || (wr_b1 && (((b1 & MD1_RSVD) != 8'h00) || (b1[MD1_RUN] && b1[MD1_LOAD])));

   assign err_now = (bus_wr || bus_rd)
                 && (!mapped || !size_ok || (bus_wr && hit_cnt) || val_bad);
   assign commit  = bus_wr && !err_now;

   assign start_o = commit && wr_b1 && b1[MD1_RUN];
   assign stop_o  = commit && wr_b1 && !b1[MD1_RUN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         md0_q <= '0;
         md1_q <= '0;
         err_o <= 1'b0;
      end else begin
         err_o <= err_now;
         if (commit && wr_b0) md0_q <= b0;
         if (commit && wr_b1) md1_q <= b1;
      end
   end

   always_comb begin
      rd_val = '0;
      if (bus_rd && !bus_wr && !err_now) begin
         if (hit_md0)      rd_val = sz2 ? {md0_q, md1_q} : {8'h00, md0_q};
         else if (hit_md1) rd_val = {8'h00, md1_q};
         else if (hit_cnt) rd_val = sz2 ? BUS_W'(cnt_view) : {8'h00, cnt_view[7:0]};
         for (int i = 0; i < NCCM; i++)
            if (hit_ccm[i]) rd_val = {8'h00, ccm_val[i]};
         for (int i = 0; i < NCMP; i++)
            if (hit_cmp[i]) rd_val = sz2 ? BUS_W'(cmp_val[i]) : {8'h00, cmp_val[i][7:0]};
      end
   end
   assign bus_rdata = rd_val;

   AST_MD0_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (md0_q & MD0_RSVD) == 8'h00); // R8
   AST_MD1_RUN_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(md1_q[MD1_RUN] && md1_q[MD1_LOAD])); // R9
   AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      err_now |=> ($stable(md0_q) && $stable(md1_q) && $stable(cmp_a) && $stable(cmp_b))); // R12

endmodule

// File: rtl/upcmp_timer.sv
module upcmp_timer
   import utmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              err_o,
   output logic              wrap_o,
   output logic              cmpa_o,
   output logic              cmpb_o
);

   if (CNT_W < 9 || CNT_W > BUS_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 9 and the bus width");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("ADDR_W must cover the 8-bit register offsets");
   end

   logic             start, stop, adv;
   logic [CNT_W-1:0] cmp_a, cmp_b, cnt_view, nxt;

   utmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .cnt_view(cnt_view),
      .bus_rdata(bus_rdata), .err_o(err_o),
      .start_o(start), .stop_o(stop), .cmp_a(cmp_a), .cmp_b(cmp_b)
   );

   utmr_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .start_i(start), .stop_i(stop), .cmp_a_i(cmp_a),
      .cnt_view_o(cnt_view), .adv_o(adv), .nxt_o(nxt),
      .wrap_o(wrap_o), .cmpa_o(cmpa_o)
   );

   utmr_match #(.CNT_W(CNT_W)) u_match (
      .clk(clk), .rst_n(rst_n), .adv_i(adv), .nxt_i(nxt),
      .cmp_b_i(cmp_b), .cmpb_o(cmpb_o)
   );

   AST_WRAP_WITH_CMPA: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o == cmpa_o); // R3

endmodule

// File: tb/upcmp_timer_tb.sv
module upcmp_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        err_o, wrap_o, cmpa_o, cmpb_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   upcmp_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .err_o(err_o), .wrap_o(wrap_o), .cmpa_o(cmpa_o), .cmpb_o(cmpb_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [15:0] d,
                     output logic e);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      e = err_o;
   endtask

   task automatic rd(input logic [7:0] a, input logic [1:0] s,
                     output logic [15:0] d, output logic e);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a; bus_size = s;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
      e = err_o;
   endtask

   task automatic ticks(input int n, output int w, output int a, output int b);
      w = 0; a = 0; b = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_i = 1'b1;
         @(negedge clk);
         tick_i = 1'b0;
         w += int'(wrap_o); a += int'(cmpa_o); b += int'(cmpb_o);
      end
   endtask

   function automatic int rdcnt_dummy(input int x); return x; endfunction

   task automatic cnt_is(input string req, input int exp);
      logic [15:0] d; logic e;
      rd(8'hA4, 2'd1, d, e);
      chk(req, int'(d), exp);
   endtask

   task automatic t_reset();
      logic [15:0] d; logic e;
      chk("R1 outputs", int'({wrap_o, cmpa_o, cmpb_o, err_o}), 0);
      cnt_is("R1 counter", 0);
      rd(8'h84, 2'd1, d, e);
      chk("R1 mode bytes", int'(d), 0);
      rd(8'hC4, 2'd1, d, e);
      chk("R1 compare A", int'(d), 0);
      rd(8'hD4, 2'd1, d, e);
      chk("R1 compare B", int'(d), 0);
   endtask

   task automatic t_compare_access();
      logic [15:0] d; logic e;
      wr(8'hC4, 2'd1, 16'h1234, e);
      rd(8'hC4, 2'd1, d, e);
      chk("R11 two-byte compare write", int'(d), 16'h1234);
      wr(8'hC4, 2'd0, 16'h00AB, e);
      rd(8'hC4, 2'd1, d, e);
      chk("R11 one-byte write keeps high byte", int'(d), 16'h12AB);
      wr(8'hB4, 2'd0, 16'h005A, e);
      rd(8'hB4, 2'd0, d, e);
      chk("R11 ccm A byte", int'(d), 16'h005A);
      wr(8'hB5, 2'd1, 16'h0077, e);
      chk("R11 ccm two-byte write err", int'(e), 1);
      rd(8'hB5, 2'd0, d, e);
      chk("R11 ccm B unchanged", int'(d), 0);
   endtask

   task automatic t_count();
      logic e; int w, a, b;
      wr(8'hC4, 2'd1, 16'd5, e);
      wr(8'hD4, 2'd1, 16'd3, e);
      wr(8'h85, 2'd0, 16'h0080, e);
      chk("R5 start err", int'(e), 0);
      cnt_is("R5 starts at zero", 0);
      ticks(3, w, a, b);
      chk("R4 cmpb on count 3", b, 1);
      chk("R3 no wrap before period", w, 0);
      cnt_is("R2 three ticks", 3);
      repeat (4) @(negedge clk);
      cnt_is("R2 idle holds count", 3);
      ticks(2, w, a, b);
      chk("R3 wrap after 5 ticks", w, 1);
      chk("R3 cmpa with wrap", a, 1);
      chk("R4 no cmpb at 4 or wrap", b, 0);
      cnt_is("R3 counter back to zero", 0);
      ticks(5, w, a, b);
      chk("R3 one wrap per period", w, 1);
      chk("R4 one cmpb per period", b, 1);
   endtask

   task automatic t_latch();
      logic e; int w, a, b;
      wr(8'hC4, 2'd1, 16'd2, e);
      ticks(5, w, a, b);
      chk("R5 period stays latched", w, 1);
      cnt_is("R5 latched period count", 0);
      wr(8'h85, 2'd0, 16'h0080, e);
      ticks(4, w, a, b);
      chk("R5 new period after restart", w, 2);
      ticks(1, w, a, b);
      cnt_is("R2 count one", 1);
      wr(8'h85, 2'd0, 16'h0080, e);
      cnt_is("R5 restart clears count", 0);
   endtask

   task automatic t_stop();
      logic e; int w, a, b;
      ticks(1, w, a, b);
      wr(8'h85, 2'd0, 16'h0000, e);
      cnt_is("R7 stopped reads zero", 0);
      ticks(3, w, a, b);
      chk("R7 no pulses when stopped", w + a + b, 0);
      cnt_is("R7 ticks ignored", 0);
   endtask

   task automatic t_zero_period();
      logic [15:0] d; logic e; int w, a, b;
      wr(8'hC4, 2'd1, 16'd0, e);
      wr(8'h85, 2'd0, 16'h0080, e);
      ticks(3, w, a, b);
      chk("R6 no pulses with zero period", w + a + b, 0);
      cnt_is("R6 counter stays zero", 0);
      rd(8'h85, 2'd0, d, e);
      chk("R6 mode byte stored", int'(d), 16'h0080);
      wr(8'h85, 2'd0, 16'h0000, e);
   endtask

   task automatic t_md0();
      logic [15:0] d; logic e;
      wr(8'h84, 2'd0, 16'h0004, e);
      chk("R8 bit2 err", int'(e), 1);
      wr(8'h84, 2'd0, 16'h0020, e);
      chk("R8 bit5 err", int'(e), 1);
      wr(8'h84, 2'd0, 16'h0008, e);
      chk("R8 bit3 err", int'(e), 1);
      rd(8'h84, 2'd0, d, e);
      chk("R8 byte0 unchanged", int'(d), 0);
      wr(8'h84, 2'd0, 16'h0001, e);
      rd(8'h84, 2'd0, d, e);
      chk("R8 legal byte0 stored", int'(d), 1);
   endtask

   task automatic t_md1();
      logic [15:0] d; logic e; int w, a, b;
      wr(8'hC4, 2'd1, 16'd4, e);
      wr(8'h85, 2'd0, 16'h00C0, e);
      chk("R9 run+load err", int'(e), 1);
      rd(8'h85, 2'd0, d, e);
      chk("R9 byte1 unchanged", int'(d), 0);
      ticks(2, w, a, b);
      cnt_is("R9 rejected write did not start", 0);
      wr(8'h85, 2'd0, 16'h0082, e);
      chk("R9 reserved bit1 err", int'(e), 1);
      wr(8'h85, 2'd0, 16'h0040, e);
      chk("R9 load alone ok", int'(e), 0);
      rd(8'h85, 2'd0, d, e);
      chk("R9 load stored", int'(d), 16'h0040);
   endtask

   task automatic t_sizes();
      logic [15:0] d; logic e; int w, a, b;
      wr(8'h84, 2'd1, 16'h0380, e);
      chk("R10 two-byte mode write ok", int'(e), 0);
      rd(8'h84, 2'd1, d, e);
      chk("R10 both bytes", int'(d), 16'h0380);
      ticks(2, w, a, b);
      cnt_is("R10 two-byte write started", 2);
      wr(8'h85, 2'd1, 16'h0000, e);
      chk("R10 two-byte at 0x85 err", int'(e), 1);
      cnt_is("R10 still running", 2);
      wr(8'h84, 2'd2, 16'h0000, e);
      chk("R10 four-byte err", int'(e), 1);
      rd(8'h85, 2'd1, d, e);
      chk("R10 two-byte read at 0x85 err", int'(e), 1);
      rd(8'h84, 2'd3, d, e);
      chk("R10 reserved size err", int'(e), 1);
   endtask

   task automatic t_bad_access();
      logic [15:0] d; logic e;
      wr(8'hA4, 2'd1, 16'h0000, e);
      chk("R12 counter write err", int'(e), 1);
      cnt_is("R12 counter unchanged", 2);
      wr(8'h10, 2'd0, 16'h00FF, e);
      chk("R12 unmapped write err", int'(e), 1);
      rd(8'h10, 2'd0, d, e);
      chk("R12 unmapped read err", int'(e), 1);
      chk("R12 unmapped read data", int'(d), 0);
      @(negedge clk);
      chk("R12 err one cycle", int'(err_o), 0);
      rd(8'h84, 2'd1, d, e);
      chk("R12 mode unchanged", int'(d), 16'h0380);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_compare_access();
      t_count();
      t_latch();
      t_stop();
      t_zero_period();
      t_md0();
      t_md1();
      t_sizes();
      t_bad_access();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule